// File: doc/BRIEF.md
# Hours-and-Minutes Timekeeping Chain

This block keeps the time of day for a digital clock. A 2 Hz tick enable arrives from an upstream divider. A prescaler turns 120 of those ticks into one minute event. The minute event advances a two-digit BCD minutes counter, and that counter's rollover advances a two-digit BCD hours counter in 24-hour form. The four BCD digits go to an external display decoder. A separator blink output flashes at about 1 Hz so that the display shows the clock is running.

A mode input chooses between running and setting. While setting, the prescaler is held at its start value and the cascade is broken. A single-cycle set strobe then advances whichever counter the select input names, and that counter wraps on its own without carrying. Each counter also has its own synchronous zero input. All logic uses one clock, and every tick and strobe is a one-cycle enable.

Top module: `clock_chain`

## Requirements
- R1: After reset all four digits read 0, the blink output is 0, and the prescaler starts at 1, so the first minute needs a full 120 ticks.
- R2: In run mode (`run_mode`=1) the prescaler counts ticks 1..120 and reloads to 1. The minutes advance by one on the 120th tick and stay unchanged for the 119 ticks before it.
- R3: In set mode (`run_mode`=0) ticks advance nothing and the prescaler is forced to 1. After a return to run mode, a full 120 ticks are needed for the next minute, whatever count was reached before.
- R4: Minutes count 00..59 in BCD (tens 0..5, units 0..9). A run-mode advance from 59 gives 00 and advances the hours by one in the same cycle.
- R5: Hours count 00..23 in BCD. In run mode, 23:59 followed by a minute event gives 00:00.
- R6: In set mode, a `set_pulse` with `set_sel`=0 advances only the minutes, and a `set_pulse` with `set_sel`=1 advances only the hours. Minutes 59 wrap to 00 with no hours change, and hours 23 wrap to 00.
- R7: In run mode `set_pulse` is ignored.
- R8: A change between modes causes no advance of either counter. The counters change only on their selected advance or their zero input.
- R9: In run mode the blink output toggles on every tick. In set mode it is held at 1.
- R10: `min_zero` clears the minutes and `hr_zero` clears the hours at the next clock edge. Each takes priority over an advance in the same cycle, and neither affects the other counter.
- R11: Digits never leave their legal range: units 0..9, minute tens 0..5, and hours at most 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_2hz | input | 1 | One-cycle enable, twice per second |
| run_mode | input | 1 | 1 = run, 0 = set |
| set_pulse | input | 1 | One-cycle set strobe, used in set mode |
| set_sel | input | 1 | Set target: 0 = minutes, 1 = hours |
| min_zero | input | 1 | Synchronous clear of the minutes |
| hr_zero | input | 1 | Synchronous clear of the hours |
| min_tens | output | 4 | Minutes tens digit, BCD |
| min_units | output | 4 | Minutes units digit, BCD |
| hr_tens | output | 4 | Hours tens digit, BCD |
| hr_units | output | 4 | Hours units digit, BCD |
| blink | output | 1 | Separator flash, about 1 Hz while running |

## Verification
The assertions check on every cycle that the digits stay in their legal ranges, that the prescaler sits at 1 in set mode, that the minute event returns it to 1, and that the blink toggles or holds as the mode requires. They also check that a counter moves only on its own advance or zero, and that a zero wins over an advance. The bench scenarios are needed for the counts that only show over many cycles: exactly 120 ticks per minute, the prescaler restart after a stay in set mode, the carry from 59 into the hours, and the wrap at 23:59. They also cover the routing of set strobes to one counter and the absence of any advance when the mode changes.

// File: rtl/clock_chain_pkg.sv
package clock_chain_pkg;

  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] units;
  } bcd2_t;

  localparam bcd2_t BCD2_ZERO = '{tens: 4'd0, units: 4'd0};

  // Increment a two-digit BCD value by one, with no range limit.
  function automatic bcd2_t bcd2_inc(input bcd2_t v);
    bcd2_t r;
    if (v.units == 4'd9) begin
      r.units = 4'd0;
      r.tens  = v.tens + 4'd1;
    end else begin
      r.units = v.units + 4'd1;
      r.tens  = v.tens;
    end
    return r;
  endfunction

  // True when a BCD pair equals a given decimal pair.
  function automatic logic bcd2_is(input bcd2_t v, input int t, input int u);
    return (v.tens == 4'(t)) && (v.units == 4'(u));
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRESCALE = 120,
  localparam int CNT_W = $clog2(PRESCALE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_mode,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             minute_evt
);

  localparam logic [CNT_W-1:0] TERM  = CNT_W'(PRESCALE);
  localparam logic [CNT_W-1:0] START = CNT_W'(1);

  // Terminal decode uses only the bits set in PRESCALE: with count bounded
  // by PRESCALE, all of them set means count == PRESCALE.
  function automatic logic term_hit(input logic [CNT_W-1:0] c);
    return (c & TERM) == TERM;
  endfunction

  logic at_term;
  assign at_term = term_hit(count);

  // Minute event: the cycle in which the top bit is about to fall (reload).
  assign minute_evt = run_mode && tick && at_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= START;
    end else if (!run_mode) begin
      count <= START;
    end else if (tick) begin
      count <= at_term ? START : count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/bcd_mod_counter.sv
module bcd_mod_counter
  import clock_chain_pkg::*;
#(
  parameter int WRAP_TENS  = 6,
  parameter int WRAP_UNITS = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  zero,
  output bcd2_t value
);

  bcd2_t stepped;
  bcd2_t next_val;

  always_comb begin
    stepped  = bcd2_inc(value);
    next_val = value;
    if (zero) begin
      next_val = BCD2_ZERO;
    end else if (adv) begin
      // Synchronous clear on reaching the wrap value.
      next_val = bcd2_is(stepped, WRAP_TENS, WRAP_UNITS) ? BCD2_ZERO : stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= BCD2_ZERO;
    else        value <= next_val;
  end

endmodule

// File: rtl/advance_router.sv
module advance_router (
  input  logic run_mode,
  input  logic set_pulse,
  input  logic set_sel,
  input  logic minute_evt,
  input  logic min_carry,
  output logic min_adv,
  output logic hr_adv
);

  logic set_min;
  logic set_hr;

  assign set_min = set_pulse && !set_sel;
  assign set_hr  = set_pulse &&  set_sel;

  // One-of-two source selection per counter.
  assign min_adv = run_mode ? minute_evt : set_min;
  assign hr_adv  = run_mode ? min_carry  : set_hr;

endmodule

// File: rtl/separator_blink.sv
module separator_blink (
  input  logic clk,
  input  logic rst_n,
  input  logic run_mode,
  input  logic tick,
  output logic blink
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         blink <= 1'b0;
    else if (!run_mode) blink <= 1'b1;
    else if (tick)      blink <= ~blink;
  end

endmodule

// File: rtl/clock_chain.sv
module clock_chain
  import clock_chain_pkg::*;
#(
  parameter int PRESCALE = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_2hz,
  input  logic       run_mode,
  input  logic       set_pulse,
  input  logic       set_sel,
  input  logic       min_zero,
  input  logic       hr_zero,
  output logic [3:0] min_tens,
  output logic [3:0] min_units,
  output logic [3:0] hr_tens,
  output logic [3:0] hr_units,
  output logic       blink
);

  localparam int CNT_W = $clog2(PRESCALE + 1);

  // Named internal events, visible to the bound checker.
  logic [CNT_W-1:0] pre_cnt;
  logic             minute_evt;
  logic             min_carry;
  logic             min_adv;
  logic             hr_adv;
  bcd2_t            min_val;
  bcd2_t            hr_val;

  tick_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_mode   (run_mode),
    .tick       (tick_2hz),
    .count      (pre_cnt),
    .minute_evt (minute_evt)
  );

  // Minutes carry: an accepted advance from 59.
  assign min_carry = min_adv && !min_zero && bcd2_is(min_val, 5, 9);

  advance_router u_route (
    .run_mode   (run_mode),
    .set_pulse  (set_pulse),
    .set_sel    (set_sel),
    .minute_evt (minute_evt),
    .min_carry  (min_carry),
    .min_adv    (min_adv),
    .hr_adv     (hr_adv)
  );

  bcd_mod_counter #(.WRAP_TENS(6), .WRAP_UNITS(0)) u_min (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (min_adv),
    .zero  (min_zero),
    .value (min_val)
  );

  bcd_mod_counter #(.WRAP_TENS(2), .WRAP_UNITS(4)) u_hr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (hr_adv),
    .zero  (hr_zero),
    .value (hr_val)
  );

  separator_blink u_blink (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_mode (run_mode),
    .tick     (tick_2hz),
    .blink    (blink)
  );

  assign min_tens  = min_val.tens;
  assign min_units = min_val.units;
  assign hr_tens   = hr_val.tens;
  assign hr_units  = hr_val.units;

endmodule

// File: rtl/clock_chain_chk.sv
module clock_chain_chk #(
  parameter int PRESCALE = 120,
  localparam int CNT_W = $clog2(PRESCALE + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_2hz,
  input logic             run_mode,
  input logic             set_pulse,
  input logic             min_zero,
  input logic             hr_zero,
  input logic             minute_evt,
  input logic             min_adv,
  input logic             hr_adv,
  input logic [CNT_W-1:0] pre_cnt,
  input logic [3:0]       min_tens,
  input logic [3:0]       min_units,
  input logic [3:0]       hr_tens,
  input logic [3:0]       hr_units,
  input logic             blink
);

  assert_digit_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (min_units <= 4'd9) && (hr_units <= 4'd9) && (min_tens <= 4'd5) &&
    ((hr_tens < 4'd2) || (hr_tens == 4'd2 && hr_units <= 4'd3)));

  assert_prescale_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_mode |=> (pre_cnt == CNT_W'(1)));

  assert_prescale_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt >= CNT_W'(1)) && (pre_cnt <= CNT_W'(PRESCALE)));

  assert_minute_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    minute_evt |=> (pre_cnt == CNT_W'(1)));

  assert_run_ignores_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && set_pulse && !minute_evt && !min_zero) |=>
      ($stable(min_tens) && $stable(min_units)));

  assert_min_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!min_adv && !min_zero) |=> ($stable(min_tens) && $stable(min_units)));

  assert_hr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hr_adv && !hr_zero) |=> ($stable(hr_tens) && $stable(hr_units)));

  assert_blink_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && tick_2hz) |=> (blink != $past(blink)));

  assert_blink_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_mode |=> blink);

  assert_min_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    min_zero |=> (min_tens == 4'd0 && min_units == 4'd0));

  assert_hr_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hr_zero |=> (hr_tens == 4'd0 && hr_units == 4'd0));

endmodule

bind clock_chain clock_chain_chk #(.PRESCALE(PRESCALE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_2hz   (tick_2hz),
  .run_mode   (run_mode),
  .set_pulse  (set_pulse),
  .min_zero   (min_zero),
  .hr_zero    (hr_zero),
  .minute_evt (minute_evt),
  .min_adv    (min_adv),
  .hr_adv     (hr_adv),
  .pre_cnt    (pre_cnt),
  .min_tens   (min_tens),
  .min_units  (min_units),
  .hr_tens    (hr_tens),
  .hr_units   (hr_units),
  .blink      (blink)
);

// File: tb/clock_chain_test.sv
`timescale 1ns/1ps
module clock_chain_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_2hz = 1'b0, run_mode = 1'b1, set_pulse = 1'b0, set_sel = 1'b0;
  logic min_zero = 1'b0, hr_zero = 1'b0;
  logic [3:0] min_tens, min_units, hr_tens, hr_units;
  logic blink;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Bench model of the time.
  int m_h = 0, m_m = 0;
  logic m_blink = 1'b0;

  always #2.5 clk = ~clk;

  clock_chain uut (
    .clk(clk), .rst_n(rst_n), .tick_2hz(tick_2hz), .run_mode(run_mode),
    .set_pulse(set_pulse), .set_sel(set_sel), .min_zero(min_zero),
    .hr_zero(hr_zero), .min_tens(min_tens), .min_units(min_units),
    .hr_tens(hr_tens), .hr_units(hr_units), .blink(blink)
  );

  task automatic check_time(input string req);
    logic [15:0] act, exp;
    act = {hr_tens, hr_units, min_tens, min_units};
    exp = {4'(m_h / 10), 4'(m_h % 10), 4'(m_m / 10), 4'(m_m % 10)};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s time actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_blink(input string req);
    checks++;
    if (blink !== m_blink) begin
      fails++;
      $display("FAIL %s blink actual %b expected %b", req, blink, m_blink);
    end
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_2hz = 1'b1;
      @(negedge clk);
      tick_2hz = 1'b0;
      if (run_mode) m_blink = ~m_blink;
    end
  endtask

  task automatic set_press(input logic sel, input int n);
    for (int i = 0; i < n; i++) begin
      set_sel = sel;
      set_pulse = 1'b1;
      @(negedge clk);
      set_pulse = 1'b0;
      if (!run_mode) begin
        if (sel) m_h = (m_h + 1) % 24;
        else     m_m = (m_m + 1) % 60;
      end
    end
  endtask

  task automatic go_set();
    run_mode = 1'b0;
    @(negedge clk);
    m_blink = 1'b1;
  endtask

  task automatic go_run();
    run_mode = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check_time("R1");
    check_blink("R1");
  endtask

  task automatic t_prescale();
    do_ticks(119);
    check_time("R2");          // 119 ticks: still 00:00 (also R1 start at 1)
    check_blink("R9");
    do_ticks(1);
    m_m = 1;
    check_time("R2");
    check_blink("R9");
  endtask

  task automatic t_set_hold();
    do_ticks(50);
    go_set();
    check_blink("R9");
    do_ticks(10);
    check_time("R3");
    check_blink("R9");
    go_run();
    repeat (3) @(negedge clk);
    check_time("R8");
    do_ticks(119);
    check_time("R3");
    do_ticks(1);
    m_m = 2;
    check_time("R3");
    check_blink("R9");
  endtask

  task automatic t_set_adjust();
    go_set();
    set_press(1'b0, 57);
    check_time("R6");          // 00:59
    set_press(1'b0, 1);
    check_time("R6");          // 00:00, no carry
    set_press(1'b1, 23);
    check_time("R6");          // 23:00
    set_press(1'b1, 1);
    check_time("R6");          // 00:00
    set_press(1'b1, 5);
    go_run();
    check_time("R8");
  endtask

  task automatic t_run_ignores_set();
    set_press(1'b0, 3);
    set_press(1'b1, 3);
    check_time("R7");
  endtask

  task automatic t_minute_carry();
    go_set();
    set_press(1'b0, 59);
    go_run();
    check_time("R4");          // 05:59
    do_ticks(120);
    m_m = 0; m_h = 6;
    check_time("R4");          // 06:00
  endtask

  task automatic t_day_wrap();
    go_set();
    set_press(1'b1, 17);
    set_press(1'b0, 59);
    go_run();
    do_ticks(119);
    check_time("R5");          // 23:59
    do_ticks(1);
    m_m = 0; m_h = 0;
    check_time("R5");          // 00:00
  endtask

  task automatic t_zero();
    go_set();
    set_press(1'b1, 3);
    set_press(1'b0, 7);
    min_zero = 1'b1;
    @(negedge clk);
    min_zero = 1'b0;
    m_m = 0;
    check_time("R10");         // 03:00
    set_press(1'b0, 4);
    hr_zero = 1'b1;
    @(negedge clk);
    hr_zero = 1'b0;
    m_h = 0;
    check_time("R10");         // 00:04
    min_zero = 1'b1;
    set_sel = 1'b0;
    set_pulse = 1'b1;
    @(negedge clk);
    set_pulse = 1'b0;
    min_zero = 1'b0;
    m_m = 0;
    check_time("R10");         // zero wins over advance
    go_run();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_set_hold();
    t_set_adjust();
    t_run_ignores_set();
    t_minute_carry();
    t_day_wrap();
    t_zero();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual hung expected finish");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule